// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block holds three programmable alarm bytes, one each for minutes, hours and day of the week. Each byte is in BCD in the same layout as the matching time field, and bit 7 of each byte is a mask. Once per hundredth of a second the surrounding clock logic presents an update strobe, the hundredths count that is about to roll over, and the next seconds, minutes, hours and day values. The block looks for the seconds-and-above rollover into a new minute. On that update it compares the unmasked fields against the alarm bytes. On a match it sets a sticky alarm flag.

The flag clears when software reads or writes any of the three alarm bytes through a small register port. The port has an address, write and read strobes, and byte data. An interrupt request is derived from the flag and an external interrupt mask, and is held in a flop. The mask blocks only the request and never the flag. Because each field has its own mask, the same hardware gives an alarm every minute, every hour, every day, or once a week.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset the flag, the interrupt request, the read data and all three alarm bytes are 0.
- R2: The alarm bytes sit at addresses 3 (minutes), 5 (hours) and 7 (day). A write to one of them stores the byte. A read strobe loads `reg_rdata` at the next clock edge, and the value then holds until the next read. The minutes and hours bytes keep all 8 bits.
- R3: Bits 6 to 3 of the day alarm byte always read 0. Bits 7 and 2 to 0 are kept.
- R4: A read of any other address returns 0. A write to any other address leaves the alarm bytes unchanged.
- R5: A qualifying update is a clock cycle with `upd_stb` high, `tm_hund` equal to 8'h99 and `tm_sec` equal to 8'h00. The comparison uses the time values presented in that same cycle. The flag is 1 after the clock edge that closes that cycle.
- R6: A field counts as matching when its mask bit (bit 7) is 1, or when its compared bits equal the time field. Minutes and hours compare bits 6 to 0, and day compares bits 2 to 0. The alarm fires when all three fields count as matching. With no masks set, this means minutes, hours and day must all be equal.
- R7: With only the day mask set, the alarm fires when minutes and hours match, whatever the day (a daily alarm).
- R8: With the day and hours masks set, the alarm fires when minutes match (an hourly alarm).
- R9: With all three masks set, the alarm fires on every qualifying update (once per minute).
- R10: The flag stays set until a read or write of address 3, 5 or 7 clears it. If a qualifying match happens in the same cycle as such an access, the flag ends up set.
- R11: Reads and writes of other addresses do not clear the flag.
- R12: `alarm_irq` equals the flag ANDed with the inverse of `irq_mask`, taken from a flop that is loaded at the same edge as the flag. `irq_mask` has no effect on the flag.
- R13: The flag does not set when `upd_stb` is low, when the hundredths value is not 8'h99, or when the next seconds value is not 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (6) | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| upd_stb | input | 1 | Once-per-hundredth update strobe |
| tm_hund | input | 8 | Hundredths value being left (BCD) |
| tm_sec | input | 8 | Next seconds value (BCD) |
| tm_min | input | 8 | Next minutes value (BCD) |
| tm_hour | input | 8 | Next hours value (BCD, bit 6 is the 12-hour select) |
| tm_day | input | 8 | Next day-of-week value |
| irq_mask | input | 1 | Blocks the interrupt request when 1 |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Registered interrupt request |

## Verification
The comparator is swept over all eight mask combinations. Under each combination, all eight patterns run in which each of minutes, hours and day either equals the alarm value or differs from it by one. This separates a field that is wrongly ignored from one that is wrongly compared, and it pins down the daily, hourly and per-minute rates. Updates that fall one hundredth early, one second late, or with no strobe at all check that only the minute rollover qualifies. Accesses that coincide with a match, accesses to foreign addresses, and toggling of the interrupt mask separate the clear priority and the flag-versus-request paths.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

  localparam int NUM_FLD  = 3;
  localparam int BYTE_W   = 8;
  localparam int MASK_BIT = 7;

  typedef enum logic [1:0] {
    FLD_MIN  = 2'd0,
    FLD_HOUR = 2'd1,
    FLD_DAY  = 2'd2
  } fld_e;

  localparam logic [BYTE_W-1:0] HUND_LAST = 8'h99;
  localparam logic [BYTE_W-1:0] SEC_FIRST = 8'h00;

  // register address of each alarm field
  function automatic int fld_addr(int f);
    case (f)
      0:       return 3;
      1:       return 5;
      default: return 7;
    endcase
  endfunction

  // bits that are stored on write
  function automatic logic [BYTE_W-1:0] fld_keep(int f);
    case (f)
      0, 1:    return 8'hFF;
      default: return 8'h87;
    endcase
  endfunction

  // bits that take part in the comparison
  function automatic logic [BYTE_W-1:0] fld_cmp(int f);
    case (f)
      0, 1:    return 8'h7F;
      default: return 8'h07;
    endcase
  endfunction

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import tod_alarm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic                              reg_wr,
  input  logic                              reg_rd,
  input  logic [BYTE_W-1:0]                 reg_wdata,
  output logic [BYTE_W-1:0]                 reg_rdata,
  output logic [NUM_FLD-1:0][BYTE_W-1:0]    al_val,
  output logic                              alarm_acc
);

  logic [NUM_FLD-1:0] sel;
  logic [BYTE_W-1:0]  al_q [NUM_FLD];
  logic [BYTE_W-1:0]  al_d [NUM_FLD];
  logic [NUM_FLD-1:0] al_en;
  logic [BYTE_W-1:0]  rd_d;
  logic [BYTE_W-1:0]  rd_q;

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    assign sel[f] = (reg_addr == ADDR_W'(fld_addr(f)));

    always_comb begin
      al_en[f] = reg_wr & sel[f];
      al_d[f]  = reg_wdata & fld_keep(f);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        al_q[f] <= '0;
      end else if (al_en[f]) begin
        al_q[f] <= al_d[f];
      end
    end

    assign al_val[f] = al_q[f];
  end

  always_comb begin
    rd_d = '0;
    for (int f = 0; f < NUM_FLD; f++) begin
      if (sel[f]) rd_d = al_q[f];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (reg_rd) begin
      rd_q <= rd_d;
    end
  end

  assign reg_rdata = rd_q;
  assign alarm_acc = (reg_wr | reg_rd) & (|sel);

endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
  import tod_alarm_pkg::*;
(
  input  logic                           upd_stb,
  input  logic [BYTE_W-1:0]              tm_hund,
  input  logic [BYTE_W-1:0]              tm_sec,
  input  logic [BYTE_W-1:0]              tm_min,
  input  logic [BYTE_W-1:0]              tm_hour,
  input  logic [BYTE_W-1:0]              tm_day,
  input  logic [NUM_FLD-1:0][BYTE_W-1:0] al_val,
  output logic                           fire
);

  logic [NUM_FLD-1:0][BYTE_W-1:0] tm_vec;
  logic [NUM_FLD-1:0]             fld_ok;
  logic                           minute_edge;

  assign tm_vec[FLD_MIN]  = tm_min;
  assign tm_vec[FLD_HOUR] = tm_hour;
  assign tm_vec[FLD_DAY]  = tm_day;

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_cmp
    logic eq;
    assign eq        = ((al_val[f] & fld_cmp(f)) == (tm_vec[f] & fld_cmp(f)));
    assign fld_ok[f] = al_val[f][MASK_BIT] | eq;
  end

  always_comb begin
    minute_edge = upd_stb & (tm_hund == HUND_LAST) & (tm_sec == SEC_FIRST);
    fire        = minute_edge & (&fld_ok);
  end

endmodule

// File: rtl/alarm_flag_irq.sv
module alarm_flag_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic alarm_acc,
  input  logic irq_mask,
  output logic alarm_flag,
  output logic alarm_irq
);

  logic flag_q, flag_d;
  logic irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    if (alarm_acc) flag_d = 1'b0;
    if (fire)      flag_d = 1'b1;   // a match outranks the clear
    irq_d = flag_d & ~irq_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign alarm_flag = flag_q;
  assign alarm_irq  = irq_q;

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              upd_stb,
  input  logic [7:0]        tm_hund,
  input  logic [7:0]        tm_sec,
  input  logic [7:0]        tm_min,
  input  logic [7:0]        tm_hour,
  input  logic [7:0]        tm_day,
  input  logic              irq_mask,
  output logic              alarm_flag,
  output logic              alarm_irq
);

  logic [NUM_FLD-1:0][BYTE_W-1:0] al_val;
  logic                           alarm_acc;
  logic                           fire;

  alarm_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .al_val    (al_val),
    .alarm_acc (alarm_acc)
  );

  alarm_matcher u_match (
    .upd_stb (upd_stb),
    .tm_hund (tm_hund),
    .tm_sec  (tm_sec),
    .tm_min  (tm_min),
    .tm_hour (tm_hour),
    .tm_day  (tm_day),
    .al_val  (al_val),
    .fire    (fire)
  );

  alarm_flag_irq u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .alarm_acc  (alarm_acc),
    .irq_mask   (irq_mask),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq)
  );

endmodule

// File: rtl/tod_alarm_match_chk.sv
module tod_alarm_match_chk
  import tod_alarm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [7:0]        reg_rdata,
  input logic              upd_stb,
  input logic [7:0]        tm_hund,
  input logic [7:0]        tm_sec,
  input logic              irq_mask,
  input logic              alarm_flag,
  input logic              alarm_irq
);

  logic is_alarm_addr, acc, qual;

  always_comb begin
    is_alarm_addr = (reg_addr == ADDR_W'(3)) || (reg_addr == ADDR_W'(5)) ||
                    (reg_addr == ADDR_W'(7));
    acc  = (reg_wr || reg_rd) && is_alarm_addr;
    qual = upd_stb && (tm_hund == 8'h99) && (tm_sec == 8'h00);
  end

  // R10: an access without a match leaves the flag clear
  a_r10_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !qual) |=> !alarm_flag);

  // R13, R5: the flag only rises after a qualifying update
  a_r13_rise_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(qual));

  // R10, R11: without an update or alarm access the flag holds
  a_r11_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual && !acc) |=> $stable(alarm_flag));

  // R12: registered request follows flag and mask
  a_r12_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq == (alarm_flag && !$past(irq_mask)));

  // R3: unused day bits read zero
  a_r3_day_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(7)) |=> (reg_rdata[6:3] == 4'b0000));

  // R4: other addresses read zero
  a_r4_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !is_alarm_addr) |=> (reg_rdata == 8'h00));

endmodule

bind tod_alarm_match tod_alarm_match_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .upd_stb    (upd_stb),
  .tm_hund    (tm_hund),
  .tm_sec     (tm_sec),
  .irq_mask   (irq_mask),
  .alarm_flag (alarm_flag),
  .alarm_irq  (alarm_irq)
);

// File: tb/tod_alarm_match_test.sv
`timescale 1ns/1ps
module tod_alarm_match_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] reg_addr;
  logic              reg_wr, reg_rd;
  logic [7:0]        reg_wdata, reg_rdata;
  logic              upd_stb;
  logic [7:0]        tm_hund, tm_sec, tm_min, tm_hour, tm_day;
  logic              irq_mask;
  logic              alarm_flag, alarm_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_alarm_match #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .upd_stb(upd_stb), .tm_hund(tm_hund), .tm_sec(tm_sec), .tm_min(tm_min),
    .tm_hour(tm_hour), .tm_day(tm_day), .irq_mask(irq_mask),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // one update strobe; optionally with a coincident alarm read
  task automatic upd(logic [7:0] h, logic [7:0] s, logic [7:0] m,
                     logic [7:0] hr, logic [7:0] d, bit with_rd);
    @(negedge clk);
    tm_hund = h; tm_sec = s; tm_min = m; tm_hour = hr; tm_day = d;
    upd_stb = 1'b1;
    if (with_rd) begin reg_addr = 3; reg_rd = 1'b1; end
    @(negedge clk);
    upd_stb = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    upd_stb = 0; tm_hund = 0; tm_sec = 0; tm_min = 0; tm_hour = 0; tm_day = 0;
    irq_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 flag", {7'b0, alarm_flag}, 8'h00);
    check("R1 irq", {7'b0, alarm_irq}, 8'h00);
    check("R1 rdata", reg_rdata, 8'h00);
    for (int a = 3; a <= 7; a += 2) begin
      rd(ADDR_W'(a), v);
      check("R1 alarm byte", v, 8'h00);
    end

    // R2 readback, R3 day bits
    wr(3, 8'hA5); rd(3, v); check("R2 minutes byte", v, 8'hA5);
    wr(5, 8'h5A); rd(5, v); check("R2 hours byte", v, 8'h5A);
    wr(7, 8'hFF); rd(7, v); check("R3 day byte", v, 8'h87);
    // R4 foreign address
    wr(6'h10, 8'h33); rd(6'h10, v); check("R4 other read", v, 8'h00);
    rd(3, v); check("R4 minutes kept", v, 8'hA5);
    rd(7, v); check("R4 day kept", v, 8'h87);

    // R5-R9 sweep: every mask combination against every match pattern
    for (int mk = 0; mk < 8; mk++) begin
      for (int p = 0; p < 8; p++) begin
        logic [7:0] m, hr, d;
        bit em, eh, ed, exp;
        string tag;
        wr(3, {mk[0], 7'h30});
        wr(5, {mk[1], 7'h12});
        wr(7, {mk[2], 7'h03});
        check("R10 write clears", {7'b0, alarm_flag}, 8'h00);
        m  = p[0] ? 8'h31 : 8'h30;
        hr = p[1] ? 8'h13 : 8'h12;
        d  = p[2] ? 8'h04 : 8'h03;
        em = (m == 8'h30); eh = (hr == 8'h12); ed = (d == 8'h03);
        exp = (mk[0] | em) & (mk[1] | eh) & (mk[2] | ed);
        case (mk)
          4:       tag = "R7 daily";
          6:       tag = "R8 hourly";
          7:       tag = "R9 per minute";
          default: tag = "R6 field match";
        endcase
        upd(8'h99, 8'h00, m, hr, d, 1'b0);
        check({tag, " R5 flag"}, {7'b0, alarm_flag}, {7'b0, exp});
        check({tag, " R12 irq"}, {7'b0, alarm_irq}, {7'b0, exp});
      end
    end

    // all masks set from here
    wr(3, 8'h80); wr(5, 8'h80); wr(7, 8'h80);
    // R13 non-qualifying updates
    upd(8'h98, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0);
    check("R13 hundredths not 99", {7'b0, alarm_flag}, 8'h00);
    upd(8'h99, 8'h01, 8'h00, 8'h00, 8'h01, 1'b0);
    check("R13 seconds not 00", {7'b0, alarm_flag}, 8'h00);
    @(negedge clk);
    tm_hund = 8'h99; tm_sec = 8'h00;
    @(negedge clk);
    check("R13 no strobe", {7'b0, alarm_flag}, 8'h00);

    // R10 match wins over coincident read
    upd(8'h99, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1);
    check("R10 match beats clear", {7'b0, alarm_flag}, 8'h01);
    // R11 foreign accesses keep the flag
    rd(6'h0B, v); wr(6'h20, 8'hFF); rd(6'h04, v);
    check("R11 flag kept", {7'b0, alarm_flag}, 8'h01);
    // R10 read clears
    rd(7, v);
    check("R10 read clears", {7'b0, alarm_flag}, 8'h00);

    // R12 mask blocks request only
    irq_mask = 1'b1;
    upd(8'h99, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0);
    check("R12 flag under mask", {7'b0, alarm_flag}, 8'h01);
    check("R12 irq masked", {7'b0, alarm_irq}, 8'h00);
    irq_mask = 1'b0;
    @(negedge clk);
    check("R12 irq after unmask", {7'b0, alarm_irq}, 8'h01);
    wr(5, 8'h80);
    check("R10 write clears flag", {7'b0, alarm_flag}, 8'h00);
    check("R12 irq follows clear", {7'b0, alarm_irq}, 8'h00);

    finish_run();
  end

endmodule